// File: doc/BRIEF.md
# Counter Underflow Interrupt Flag Controller

This block gathers underflow events from five event counters and keeps each one as a sticky interrupt request flag. When a counter reaches its terminal count and underflows, it pulses its event input for one clock. The matching flag then stays at 1 until software clears it. A separate enable register decides which flags are passed on as interrupt requests.

Software reaches the block through a small byte-wide register port with address, write data, write strobe, read strobe and read data. There are two registers at consecutive byte offsets: the flag (status) register comes first and the enable register follows it. Software clears a flag by writing 0 to its bit. A bit written with 1 keeps its value. An event in the same cycle as a clear wins, so no underflow is lost. The block drives five masked per-source requests and one combined interrupt output. The combined output comes from a register.

Top module: `uflow_irq_flags`

## Requirements
- R1: After reset, both registers read 0x00, `src_req` is 0 and `irq_out` is 0.
- R2: A one-cycle pulse on `evt_uflow[i]` sets bit i of the status register, at byte offset `STAT_OFS` (default 2), on the next clock edge. The bit stays set until software clears it.
- R3: A write to the status offset clears each bit i (0 to 4) whose written data bit is 0. Each bit written with 1 keeps its previous value.
- R4: If `evt_uflow[i]` and a write of 0 to status bit i occur in the same cycle, the bit ends up 1.
- R5: The enable register at offset `STAT_OFS+1` has read/write bits 0 to 4, with bit i belonging to source i. One write updates all five bits. Without a write, the bits keep their values.
- R6: `src_req[i]` is status bit i AND enable bit i. A masked source still sets its status bit. Enabling that source later raises `src_req[i]` in the cycle after the enable write.
- R7: `irq_out` equals the OR of `src_req` from the previous clock cycle.
- R8: Bits 7 to 5 of both registers always read 0. Writing 1 to them has no effect.
- R9: `reg_rdata` shows the addressed register in the cycle after `reg_rd` is asserted and is 0x00 otherwise. A read changes no state. A read of any other offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| evt_uflow | input | 5 | Underflow pulses, one per counter |
| src_req | output | 5 | Masked request per source |
| irq_out | output | 1 | Registered OR of all masked requests |

## Verification
Events are driven as single pulses and as several sources at once, so a flag mix-up between bits shows up. Status writes use mixed data patterns such as 0x0A and 0xF5, which separate a correct write-0-to-clear from a plain store or a write-1-to-clear. An event that coincides with a clear of the same bit, and one that coincides with a clear of a different bit, show whether the set really takes priority. Masking, late enabling, writes to the padding bits and reads of unmapped offsets check the request path and the register decode.

// File: rtl/uflow_irq_flags.sv
module uflow_irq_flags #(
  parameter int N_SRC    = 5,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  input  logic [N_SRC-1:0]  evt_uflow,
  output logic [N_SRC-1:0]  src_req,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(STAT_OFS + 1);
  localparam int PAD = 8 - N_SRC;

  logic [N_SRC-1:0] flag_q, en_q;
  logic             hit_stat, hit_en;

  assign hit_stat = reg_wr && (reg_addr == A_STAT);
  assign hit_en   = reg_wr && (reg_addr == A_EN);

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            flag_q[i] <= 1'b0;
      else if (evt_uflow[i]) flag_q[i] <= 1'b1;
      else if (hit_stat && !reg_wdata[i]) flag_q[i] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      en_q <= '0;
    else if (hit_en) en_q <= reg_wdata[N_SRC-1:0];

  assign src_req = flag_q & en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |src_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              reg_rdata <= 8'h00;
    else if (!reg_rd)        reg_rdata <= 8'h00;
    else if (reg_addr == A_STAT) reg_rdata <= {{PAD{1'b0}}, flag_q};
    else if (reg_addr == A_EN)   reg_rdata <= {{PAD{1'b0}}, en_q};
    else                     reg_rdata <= 8'h00;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_uflow |=> ((flag_q & $past(evt_uflow)) == $past(evt_uflow))); // R2
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_uflow == '0) |=> ((flag_q & ~$past(flag_q)) == '0)); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_en |=> $stable(en_q)); // R5
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == |$past(src_req))); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:N_SRC] == '0); // R8
  AST_IDLE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == 8'h00)); // R9
endmodule

// File: tb/uflow_irq_flags_test.sv
module uflow_irq_flags_test;
  logic       clk = 0, rst_n = 0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       reg_wr = 0, reg_rd = 0;
  logic [4:0] evt_uflow = '0, src_req;
  logic       irq_out;
  int n_chk = 0, n_bad = 0;
  localparam logic [3:0] STAT = 4'd2, EN = 4'd3;

  uflow_irq_flags uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .evt_uflow(evt_uflow),
    .src_req(src_req), .irq_out(irq_out));

  always #2 clk = ~clk;

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, logic [4:0] e = '0);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1; evt_uflow = e;
    @(negedge clk); reg_wr = 0; evt_uflow = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(logic [4:0] e);
    @(negedge clk); evt_uflow = e;
    @(negedge clk); evt_uflow = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(STAT, d); chk("R1 status", d, 8'h00);
    rd(EN, d);   chk("R1 enable", d, 8'h00);
    chk("R1 src_req", {3'b0, src_req}, 8'h00);
    chk("R1 irq_out", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_set_clear();
    logic [7:0] d;
    pulse(5'b00100); rd(STAT, d); chk("R2 single event", d, 8'h04);
    pulse(5'b10011); rd(STAT, d); chk("R2 multi event", d, 8'h17);
    rd(STAT, d); chk("R9 read no side effect", d, 8'h17);
    wr(STAT, 8'h0A); rd(STAT, d); chk("R3 write0 clears write1 keeps", d, 8'h02);
    wr(STAT, 8'hFF); rd(STAT, d); chk("R3 all ones no effect", d, 8'h02);
    wr(STAT, 8'h00); rd(STAT, d); chk("R3 clear all", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse(5'b01001);
    wr(STAT, 8'h00, 5'b00001); rd(STAT, d); chk("R4 set beats clear", d, 8'h01);
    wr(STAT, 8'hF5, 5'b00010); rd(STAT, d); chk("R4 other bit event", d, 8'h03);
    wr(STAT, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(EN, 8'h05); rd(EN, d); chk("R5 enable rw", d, 8'h05);
    pulse(5'b00010);
    chk("R6 masked src_req", {3'b0, src_req}, 8'h00);
    rd(STAT, d); chk("R6 masked still sets", d, 8'h02);
    chk("R7 irq idle", {7'b0, irq_out}, 8'h00);
    @(negedge clk); reg_addr = EN; reg_wdata = 8'h07; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    chk("R6 late enable", {3'b0, src_req}, 8'h02);
    chk("R7 irq lags", {7'b0, irq_out}, 8'h00);
    @(negedge clk); chk("R7 irq up", {7'b0, irq_out}, 8'h01);
    wr(STAT, 8'h00);
    chk("R6 cleared", {3'b0, src_req}, 8'h00);
    chk("R7 irq still up", {7'b0, irq_out}, 8'h01);
    @(negedge clk); chk("R7 irq down", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_pad();
    logic [7:0] d;
    wr(EN, 8'hE8); rd(EN, d); chk("R8 enable pad", d, 8'h08);
    pulse(5'b11111); wr(STAT, 8'hE0); rd(STAT, d); chk("R8 status pad", d, 8'h00);
    rd(4'd7, d); chk("R9 unmapped", d, 8'h00);
    wr(4'd0, 8'hFF); rd(EN, d); chk("R9 unmapped write", d, 8'h08);
    @(negedge clk); chk("R9 idle rdata", reg_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_set_clear();
    t_collide();
    t_mask();
    t_pad();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule